// File: doc/BRIEF.md
# Periodic Microframe Admission Scheduler

This block decides, within every high-speed microframe, which periodic interrupt entries are allowed to launch a transaction. It keeps a small table of entries. Each entry has a valid flag, an 8-bit microframe selection mask and a payload length in bytes. A microframe timer counts byte-times and defines the microframe boundaries. A frame counter advances at each boundary, and its three low bits pick one bit of every entry's mask.

After each boundary the scheduler visits the table from entry 0 upward. An entry whose selected mask bit is set becomes a candidate. The scheduler then estimates the cost of the transaction as payload plus a fixed protocol overhead. It launches the transaction only if that cost still fits before a guard point placed a fixed number of byte-times ahead of the microframe end. Each launch is a start pulse carrying the entry number, and the scheduler waits for a done pulse before it looks at the next entry.

The first candidate that does not fit is recorded as dropped. Nothing else is launched in that microframe, and the drop is not carried over to later microframes. At each boundary the block presents, for one cycle, a bitmap of the entries launched and a bitmap of the entries dropped in the microframe that just ended. Software places entries in different microframes by choosing different mask bits.

Top module: `periodic_admit`

## Requirements
- R1: An entry is a candidate only if it is valid, its mask is non-zero and the mask bit numbered by frameIndex[2:0] is 1. For example, mask 8'b0010_0000 makes the entry a candidate only in microframes whose index ends in 3'b101.
- R2: An entry with its valid flag at 0, or with a mask of all zeros, is never started.
- R3: A candidate is started only when payload + OVERHEAD_BYTES + GUARD_BYTES is no greater than the byte-times left in the current microframe. A candidate that fails this test is not started, and its bit is set in the dropped bitmap.
- R4: After a drop, no further entry is started in that microframe. The next microframe walks again from entry 0, and the dropped entry is not retried first.
- R5: The table stays unchanged and the same mask bit keeps recurring. Every microframe that selects that bit then shows the same drop, and the other microframes show nothing.
- R6: Entries that would overflow one microframe together are all served when their masks select different microframes, and none of them is dropped.
- R7: Entries are started in ascending index order, with at most one transaction outstanding. The next entry is evaluated only after the done pulse for the current one.
- R8: A microframe boundary aborts a walk still waiting for done. The new microframe restarts the walk at entry 0.
- R9: A boundary occurs every UFRAME_BYTES byte ticks. frameIndex increments by one at each boundary and wraps modulo 2^FRAME_W.
- R10: statusValid is high for exactly one cycle at each boundary, carrying startedMap and droppedMap for the microframe that ended (bit i = entry i). droppedMap holds only the entry that failed the fit test, and no bit is set in both maps.
- R11: Reset clears frameIndex, the microframe timer, both bitmaps, statusValid and txStart, and it invalidates every table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteTick | input | 1 | One byte-time elapsed |
| cfgWrite | input | 1 | Write one table entry |
| cfgIndex | input | $clog2(NUM_ENTRIES) | Entry written |
| cfgValid | input | 1 | Valid flag written |
| cfgMask | input | 8 | Microframe selection mask written |
| cfgBytes | input | BYTES_W | Payload length written |
| txStart | output | 1 | One-cycle transaction launch |
| txIndex | output | $clog2(NUM_ENTRIES) | Entry launched |
| txDone | input | 1 | Transaction finished pulse |
| frameIndex | output | FRAME_W | Current microframe number |
| statusValid | output | 1 | Boundary report strobe |
| startedMap | output | NUM_ENTRIES | Entries launched in the ended microframe |
| droppedMap | output | NUM_ENTRIES | Entry dropped by the fit test |

## Verification
The bench builds the block with 8 entries, a 600 byte-time microframe, a 64 byte-time guard, a 30-byte overhead and a 4-bit frame counter. It holds byteTick high and answers each start after the transaction's own cost in cycles. With these values three 200-byte payloads overflow one microframe with wide timing margins, so each fit decision is clear-cut. The counter also wraps after sixteen microframes, which lets the bench observe the wrap and the full repeat pattern of the mask bits within a short run.

// File: rtl/periodic_admit_pkg.sv
package periodic_admit_pkg;

  typedef enum logic [1:0] {
    ST_SCAN,
    ST_WAIT,
    ST_HALT
  } walk_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic startTx;
    logic dropTx;
  } ctl_strobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic uframeEnd;
    logic candidate;
    logic fits;
  } dp_flags_t;

endpackage

// File: rtl/periodic_admit_table.sv
module periodic_admit_table #(
  parameter int NUM_ENTRIES = 8,
  parameter int BYTES_W     = 11,
  localparam int ENT_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WALK_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrite,
  input  logic [ENT_W-1:0]   cfgIndex,
  input  logic               cfgValid,
  input  logic [7:0]         cfgMask,
  input  logic [BYTES_W-1:0] cfgBytes,
  input  logic [WALK_W-1:0]  rdIdx,
  output logic               rdValid,
  output logic [7:0]         rdMask,
  output logic [BYTES_W-1:0] rdBytes
);

  logic [NUM_ENTRIES-1:0] validQ;
  logic [7:0]             maskQ  [NUM_ENTRIES];
  logic [BYTES_W-1:0]     bytesQ [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = cfgWrite && (cfgIndex == ENT_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
        maskQ[e]  <= '0;
        bytesQ[e] <= '0;
      end else if (hit) begin
        validQ[e] <= cfgValid;
        maskQ[e]  <= cfgMask;
        bytesQ[e] <= cfgBytes;
      end
    end
  end

  logic             inRange;
  logic [ENT_W-1:0] rdSel;

  assign inRange = (32'(rdIdx) < NUM_ENTRIES);
  assign rdSel   = rdIdx[ENT_W-1:0];

  always_comb begin
    rdValid = 1'b0;
    rdMask  = '0;
    rdBytes = '0;
    if (inRange) begin
      rdValid = validQ[rdSel];
      rdMask  = maskQ[rdSel];
      rdBytes = bytesQ[rdSel];
    end
  end

endmodule

// File: rtl/periodic_admit_dp.sv
module periodic_admit_dp
  import periodic_admit_pkg::*;
#(
  parameter int NUM_ENTRIES    = 8,
  parameter int BYTES_W        = 11,
  parameter int FRAME_W        = 14,
  parameter int UFRAME_BYTES   = 7500,
  parameter int GUARD_BYTES    = 64,
  parameter int OVERHEAD_BYTES = 30,
  localparam int WALK_W = $clog2(NUM_ENTRIES + 1),
  localparam int TIME_W = $clog2(UFRAME_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   byteTick,
  input  logic [WALK_W-1:0]      walkIdx,
  input  ctl_strobe_t            strobe,
  input  logic                   rdValid,
  input  logic [7:0]             rdMask,
  input  logic [BYTES_W-1:0]     rdBytes,
  output dp_flags_t              flags,
  output logic [FRAME_W-1:0]     frameIndex,
  output logic                   statusValid,
  output logic [NUM_ENTRIES-1:0] startedMap,
  output logic [NUM_ENTRIES-1:0] droppedMap
);

  localparam logic [TIME_W-1:0]      TIME_TOP  = TIME_W'(UFRAME_BYTES - 1);
  localparam logic [NUM_ENTRIES-1:0] ENT_ONE   = NUM_ENTRIES'(1);
  localparam logic [31:0]            FIXED_ADD = 32'(OVERHEAD_BYTES + GUARD_BYTES);

  logic [TIME_W-1:0]      timeLeft;
  logic [NUM_ENTRIES-1:0] accStarted;
  logic [NUM_ENTRIES-1:0] accDropped;
  logic                   boundary;
  logic [31:0]            needBytes;

  // microframe timer
  assign boundary = byteTick && (timeLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeLeft   <= TIME_TOP;
      frameIndex <= '0;
    end else if (byteTick) begin
      if (boundary) begin
        timeLeft   <= TIME_TOP;
        frameIndex <= frameIndex + 1'b1;
      end else begin
        timeLeft <= timeLeft - 1'b1;
      end
    end
  end

  // candidate selection and fit estimate
  assign needBytes       = 32'(rdBytes) + FIXED_ADD;
  assign flags.uframeEnd = boundary;
  assign flags.candidate = rdValid && (rdMask != 8'h00) && rdMask[frameIndex[2:0]];
  assign flags.fits      = (32'(timeLeft) >= needBytes);

  // per-microframe status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accStarted  <= '0;
      accDropped  <= '0;
      startedMap  <= '0;
      droppedMap  <= '0;
      statusValid <= 1'b0;
    end else if (boundary) begin
      startedMap  <= accStarted;
      droppedMap  <= accDropped;
      statusValid <= 1'b1;
      accStarted  <= '0;
      accDropped  <= '0;
    end else begin
      statusValid <= 1'b0;
      if (strobe.startTx) accStarted <= accStarted | (ENT_ONE << walkIdx);
      if (strobe.dropTx)  accDropped <= accDropped | (ENT_ONE << walkIdx);
    end
  end

endmodule

// File: rtl/periodic_admit_ctl.sv
module periodic_admit_ctl
  import periodic_admit_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int ENT_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WALK_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_flags_t         flags,
  input  logic              txDone,
  output ctl_strobe_t       strobe,
  output logic [WALK_W-1:0] walkIdx,
  output logic              txStart,
  output logic [ENT_W-1:0]  txIndex
);

  localparam logic [WALK_W-1:0] WALK_END = WALK_W'(NUM_ENTRIES);

  walk_state_e state;
  logic        evalNow;

  assign evalNow        = (state == ST_SCAN) && !flags.uframeEnd &&
                          (walkIdx < WALK_END) && flags.candidate;
  assign strobe.startTx = evalNow && flags.fits;
  assign strobe.dropTx  = evalNow && !flags.fits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_SCAN;
      walkIdx <= '0;
      txStart <= 1'b0;
      txIndex <= '0;
    end else if (flags.uframeEnd) begin
      state   <= ST_SCAN;
      walkIdx <= '0;
      txStart <= 1'b0;
    end else begin
      txStart <= 1'b0;
      unique case (state)
        ST_SCAN: begin
          if (walkIdx >= WALK_END) begin
            state <= ST_HALT;
          end else if (strobe.startTx) begin
            txStart <= 1'b1;
            txIndex <= walkIdx[ENT_W-1:0];
            state   <= ST_WAIT;
          end else if (strobe.dropTx) begin
            state <= ST_HALT;
          end else begin
            walkIdx <= walkIdx + 1'b1;
          end
        end
        ST_WAIT: begin
          if (txDone) begin
            walkIdx <= walkIdx + 1'b1;
            state   <= ST_SCAN;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

endmodule

// File: rtl/periodic_admit.sv
module periodic_admit
  import periodic_admit_pkg::*;
#(
  parameter int NUM_ENTRIES    = 8,
  parameter int BYTES_W        = 11,
  parameter int FRAME_W        = 14,
  parameter int UFRAME_BYTES   = 7500,
  parameter int GUARD_BYTES    = 64,
  parameter int OVERHEAD_BYTES = 30,
  localparam int ENT_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WALK_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   byteTick,
  input  logic                   cfgWrite,
  input  logic [ENT_W-1:0]       cfgIndex,
  input  logic                   cfgValid,
  input  logic [7:0]             cfgMask,
  input  logic [BYTES_W-1:0]     cfgBytes,
  output logic                   txStart,
  output logic [ENT_W-1:0]       txIndex,
  input  logic                   txDone,
  output logic [FRAME_W-1:0]     frameIndex,
  output logic                   statusValid,
  output logic [NUM_ENTRIES-1:0] startedMap,
  output logic [NUM_ENTRIES-1:0] droppedMap
);

  ctl_strobe_t        ctlStrobe;
  dp_flags_t          dpFlags;
  logic [WALK_W-1:0]  walkIdx;
  logic               rdValid;
  logic [7:0]         rdMask;
  logic [BYTES_W-1:0] rdBytes;
  logic               walkDrop;

  assign walkDrop = ctlStrobe.dropTx;

  periodic_admit_table #(
    .NUM_ENTRIES(NUM_ENTRIES), .BYTES_W(BYTES_W)
  ) u_table (
    .clk(clk), .rstN(rstN),
    .cfgWrite(cfgWrite), .cfgIndex(cfgIndex), .cfgValid(cfgValid),
    .cfgMask(cfgMask), .cfgBytes(cfgBytes),
    .rdIdx(walkIdx), .rdValid(rdValid), .rdMask(rdMask), .rdBytes(rdBytes)
  );

  periodic_admit_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .BYTES_W(BYTES_W), .FRAME_W(FRAME_W),
    .UFRAME_BYTES(UFRAME_BYTES), .GUARD_BYTES(GUARD_BYTES),
    .OVERHEAD_BYTES(OVERHEAD_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .byteTick(byteTick),
    .walkIdx(walkIdx), .strobe(ctlStrobe),
    .rdValid(rdValid), .rdMask(rdMask), .rdBytes(rdBytes),
    .flags(dpFlags), .frameIndex(frameIndex), .statusValid(statusValid),
    .startedMap(startedMap), .droppedMap(droppedMap)
  );

  periodic_admit_ctl #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .flags(dpFlags), .txDone(txDone),
    .strobe(ctlStrobe), .walkIdx(walkIdx),
    .txStart(txStart), .txIndex(txIndex)
  );

endmodule

// File: rtl/periodic_admit_chk.sv
module periodic_admit_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int FRAME_W     = 14
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   txStart,
  input logic                   txDone,
  input logic                   statusValid,
  input logic [FRAME_W-1:0]     frameIndex,
  input logic [NUM_ENTRIES-1:0] startedMap,
  input logic [NUM_ENTRIES-1:0] droppedMap,
  input logic                   walkDrop
);

  logic outstanding;
  logic dropSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      dropSeen    <= 1'b0;
    end else begin
      if (txStart)                     outstanding <= 1'b1;
      else if (txDone || statusValid)  outstanding <= 1'b0;
      dropSeen <= statusValid ? walkDrop : (dropSeen | walkDrop);
    end
  end

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !outstanding);

  assert_no_start_after_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !dropSeen);

  assert_status_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  assert_maps_disjoint_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> ((startedMap & droppedMap) == '0));

  assert_single_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> $onehot0(droppedMap));

  assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> (frameIndex == FRAME_W'($past(frameIndex) + 1'b1)));

  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !statusValid |-> $stable(frameIndex));

endmodule

bind periodic_admit periodic_admit_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rstN(rstN), .txStart(txStart), .txDone(txDone),
  .statusValid(statusValid), .frameIndex(frameIndex),
  .startedMap(startedMap), .droppedMap(droppedMap), .walkDrop(walkDrop)
);

// File: tb/periodic_admit_bench.sv
module periodic_admit_bench;

  localparam int N   = 8;
  localparam int BW  = 11;
  localparam int FW  = 4;
  localparam int UF  = 600;
  localparam int GB  = 64;
  localparam int OH  = 30;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          byteTick = 1'b1;
  logic          cfgWrite = 1'b0;
  logic [2:0]    cfgIndex = '0;
  logic          cfgValid = 1'b0;
  logic [7:0]    cfgMask = '0;
  logic [BW-1:0] cfgBytes = '0;
  logic          txStart;
  logic [2:0]    txIndex;
  logic          txDone = 1'b0;
  logic [FW-1:0] frameIndex;
  logic          statusValid;
  logic [N-1:0]  startedMap;
  logic [N-1:0]  droppedMap;

  always #5 clk = ~clk;

  periodic_admit #(
    .NUM_ENTRIES(N), .BYTES_W(BW), .FRAME_W(FW), .UFRAME_BYTES(UF),
    .GUARD_BYTES(GB), .OVERHEAD_BYTES(OH)
  ) u_periodic_admit (
    .clk(clk), .rstN(rstN), .byteTick(byteTick),
    .cfgWrite(cfgWrite), .cfgIndex(cfgIndex), .cfgValid(cfgValid),
    .cfgMask(cfgMask), .cfgBytes(cfgBytes),
    .txStart(txStart), .txIndex(txIndex), .txDone(txDone),
    .frameIndex(frameIndex), .statusValid(statusValid),
    .startedMap(startedMap), .droppedMap(droppedMap)
  );

  int checks = 0;
  int failures = 0;
  int bnd = 0;
  int startCnt = 0;
  int startLog [256];
  int shBytes [N];
  bit abortMode = 1'b0;
  logic [N-1:0] lastStarted = '0;
  logic [N-1:0] lastDropped = '0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // observer of ports
  always @(negedge clk) begin
    if (statusValid) begin
      bnd <= bnd + 1;
      lastStarted <= startedMap;
      lastDropped <= droppedMap;
    end
    if (txStart) begin
      startLog[startCnt % 256] <= int'(txIndex);
      startCnt <= startCnt + 1;
    end
  end

  // transaction responder: done after cost byte-times
  initial begin
    forever begin
      @(negedge clk);
      if (txStart) begin
        if (abortMode) begin
          abortMode = 1'b0;
        end else begin
          int lat;
          lat = shBytes[txIndex] + OH - 1;
          repeat (lat) @(negedge clk);
          txDone = 1'b1;
          @(negedge clk);
          txDone = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  task automatic waitBoundary();
    do @(negedge clk); while (!statusValid);
    #1;
  endtask

  task automatic setEntry(input int idx, input bit v, input logic [7:0] m, input int b);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgIndex = 3'(idx);
    cfgValid = v;
    cfgMask  = m;
    cfgBytes = BW'(b);
    shBytes[idx] = b;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic clearTable();
    for (int i = 0; i < N; i++) setEntry(i, 1'b0, 8'h00, 0);
  endtask

  task automatic testReset();
    int cnt;
    @(negedge clk);
    check("R11 frameIndex", int'(frameIndex), 0);
    check("R11 statusValid", int'(statusValid), 0);
    check("R11 startedMap", int'(startedMap), 0);
    check("R11 droppedMap", int'(droppedMap), 0);
    check("R11 txStart", int'(txStart), 0);
    cnt = 1;
    while (!statusValid) begin @(negedge clk); cnt++; end
    #1;
    check("R9 boundary period", cnt, UF);
    check("R9 frame step", int'(frameIndex), 1);
    check("R10 empty table status", int'(lastStarted), 0);
    @(negedge clk);
    check("R10 one-cycle strobe", int'(statusValid), 0);
  endtask

  task automatic testMaskSelect();
    clearTable();
    setEntry(0, 1'b1, 8'b0010_0000, 10);
    waitBoundary();
    for (int f = 0; f < 8; f++) begin
      waitBoundary();
      check("R1 mask bit selects microframe", int'(lastStarted),
            (((bnd - 1) % 8) == 5) ? 1 : 0);
      check("R9 frame counter", int'(frameIndex), bnd % 16);
    end
  endtask

  task automatic testInvalid();
    clearTable();
    setEntry(0, 1'b0, 8'hFF, 5);
    setEntry(1, 1'b1, 8'h00, 5);
    setEntry(2, 1'b1, 8'hFF, 5);
    waitBoundary();
    for (int f = 0; f < 2; f++) begin
      waitBoundary();
      check("R2 invalid or zero-mask entry skipped", int'(lastStarted), 4);
      check("R2 nothing dropped", int'(lastDropped), 0);
    end
  endtask

  task automatic testFit();
    int s0;
    clearTable();
    for (int i = 0; i < 3; i++) setEntry(i, 1'b1, 8'hFF, 200);
    setEntry(3, 1'b1, 8'hFF, 0);
    waitBoundary();
    s0 = startCnt;
    waitBoundary();
    check("R3 fitting entries started", int'(lastStarted), 3);
    check("R3 non-fitting entry dropped", int'(lastDropped), 4);
    check("R4 later small entry skipped", int'(lastStarted[3]), 0);
    check("R7 start count", startCnt - s0, 2);
    check("R7 first start index", startLog[s0 % 256], 0);
    check("R7 second start index", startLog[(s0 + 1) % 256], 1);
    waitBoundary();
    check("R4 next microframe restarts at 0", int'(lastStarted), 3);
    check("R4 same drop again", int'(lastDropped), 4);
  endtask

  task automatic testRepeat();
    clearTable();
    for (int i = 0; i < 3; i++) setEntry(i, 1'b1, 8'h01, 200);
    waitBoundary();
    for (int f = 0; f < 17; f++) begin
      waitBoundary();
      check("R5 recurring drop", int'(lastDropped),
            (((bnd - 1) % 8) == 0) ? 4 : 0);
    end
  endtask

  task automatic testSpread();
    logic [N-1:0] orS;
    logic [N-1:0] orD;
    orS = '0;
    orD = '0;
    clearTable();
    setEntry(0, 1'b1, 8'h01, 200);
    setEntry(1, 1'b1, 8'h02, 200);
    setEntry(2, 1'b1, 8'h04, 200);
    waitBoundary();
    for (int f = 0; f < 8; f++) begin
      waitBoundary();
      orS = orS | lastStarted;
      orD = orD | lastDropped;
    end
    check("R6 all spread entries served", int'(orS), 7);
    check("R6 no spread entry dropped", int'(orD), 0);
  endtask

  task automatic testAbort();
    int s1;
    clearTable();
    setEntry(0, 1'b1, 8'hFF, 100);
    setEntry(1, 1'b1, 8'hFF, 10);
    waitBoundary();
    abortMode = 1'b1;
    waitBoundary();
    check("R8 walk stuck waiting", int'(lastStarted), 1);
    check("R8 no drop when waiting", int'(lastDropped), 0);
    s1 = startCnt;
    waitBoundary();
    check("R8 restart at entry 0", startLog[s1 % 256], 0);
    check("R8 both served after restart", int'(lastStarted), 3);
  endtask

  initial begin
    for (int i = 0; i < N; i++) shBytes[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMaskSelect();
    testInvalid();
    testFit();
    testRepeat();
    testSpread();
    testAbort();
    check("R9 wrap modulo 16", int'(frameIndex), bnd % 16);
    finishRun();
  end

endmodule